// File: doc/BRIEF.md
# Dual-Mode Countdown Stop Timer

This block is a minutes:seconds countdown timer with two presets, a short one of 30 seconds and a long one of one minute. It is driven by a one-second tick and by two push-button pulses, which have already been debounced. The two buttons are shared across four commands: choosing the mode, reloading the preset, starting and stopping. A small state machine decides which command a press means, given whether the timer is running and whether the count has reached zero.

The count is kept as four BCD digits: minutes tens, minutes ones, seconds tens and seconds ones. These digits drive the display logic directly. When a decrement crosses a minute boundary, the seconds-tens digit wraps from 0 to 5 and the minute digits borrow, so 1:00 becomes 0:59. When the count reaches 0:00 the timer stops, holds the count and raises the done flag. A press on the run button at that point reloads the preset for the current mode.

Seven-segment encoding, display multiplexing, debouncing and generation of the tick are done outside this block.

Top module: `stop_timer_dual`

## Requirements
- R1: After a synchronous reset the timer is in short mode and stopped, the digits read 0,0,3,0 (minutes tens, minutes ones, seconds tens, seconds ones), and done is low.
- R2: A btn_mode pulse while the timer is stopped switches between short mode (0:30) and long mode (1:00) and loads the preset of the new mode.
- R3: A btn_mode pulse while the timer is running has no effect on the mode or on the count.
- R4: A btn_run pulse with a nonzero count toggles between running and stopped. While running, each tick lowers the count by exactly one second. While stopped, ticks are ignored.
- R5: Decrements use BCD with borrow. The seconds-ones digit goes from 0 to 9, the seconds-tens digit goes from 0 to 5 and borrows from the minutes, so 1:00 is followed by 0:59. Every digit stays a valid BCD value, and seconds tens never exceeds 5.
- R6: When the count reaches 0:00 the timer stops. Later ticks leave it at 0:00, and done is high exactly while the count is 0:00.
- R7: A btn_run pulse while the count is 0:00 reloads the preset of the current mode and leaves the timer stopped.
- R8: When inputs arrive together, btn_run takes priority over btn_mode and over tick. A btn_run pulse together with a tick while running stops the timer without decrementing. A btn_run pulse together with a tick while stopped starts the timer without decrementing. A btn_mode pulse together with btn_run is ignored.
- R9: Every command appears on the digit and done outputs at the first clock edge that samples its input pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1s | input | 1 | One-cycle pulse once per second |
| btn_mode | input | 1 | Debounced one-cycle pulse: mode select |
| btn_run | input | 1 | Debounced one-cycle pulse: start, stop or reload |
| min_tens | output | 4 | Minutes tens BCD digit |
| min_ones | output | 4 | Minutes ones BCD digit |
| sec_tens | output | 4 | Seconds tens BCD digit |
| sec_ones | output | 4 | Seconds ones BCD digit |
| done | output | 1 | High while the count is 0:00 |

## Verification
The mode and run state are not outputs, so a wrong internal state is seen only through the digits. A wrong mode bit shows at the next mode switch or reload, which loads the wrong preset. A wrong run bit shows at the next tick, which either moves a count that should hold or leaves unchanged a count that should move. A bad borrow is visible in the cycle after the tick that crosses a :x0 or 1:00 boundary. The bench keeps a seconds-count model of the timer and compares all four digits and done after every clock edge, so any of these faults is caught in the cycle it first shows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DIG_W = 4;

    typedef logic [DIG_W-1:0] digit_t;

    typedef struct packed {
        digit_t min_t;
        digit_t min_o;
        digit_t sec_t;
        digit_t sec_o;
    } mmss_t;

    typedef enum logic {
        MODE_SHORT = 1'b0,
        MODE_LONG  = 1'b1
    } mode_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_RELOAD = 3'd1,
        CMD_TOGGLE = 3'd2,
        CMD_MODE   = 3'd3,
        CMD_TICK   = 3'd4
    } cmd_e;

    // Convert a whole number of seconds into four BCD digits (m:ss).
    function automatic mmss_t secs_to_mmss(input int unsigned secs);
        mmss_t r;
        int unsigned mins;
        int unsigned rem;
        mins    = secs / 60;
        rem     = secs % 60;
        r.min_t = digit_t'((mins / 10) % 10);
        r.min_o = digit_t'(mins % 10);
        r.sec_t = digit_t'(rem / 10);
        r.sec_o = digit_t'(rem % 10);
        return r;
    endfunction

    // One-second BCD decrement with borrow; the caller never passes 0:00.
    function automatic mmss_t mmss_dec(input mmss_t t);
        mmss_t r;
        r = t;
        if (t.sec_o != 4'd0) begin
            r.sec_o = t.sec_o - 4'd1;
        end else begin
            r.sec_o = 4'd9;
            if (t.sec_t != 4'd0) begin
                r.sec_t = t.sec_t - 4'd1;
            end else begin
                r.sec_t = 4'd5;
                if (t.min_o != 4'd0) begin
                    r.min_o = t.min_o - 4'd1;
                end else begin
                    r.min_o = 4'd9;
                    r.min_t = t.min_t - 4'd1;
                end
            end
        end
        return r;
    endfunction

    function automatic logic mmss_is_zero(input mmss_t t);
        return (t == '0);
    endfunction

    function automatic logic mmss_is_one(input mmss_t t);
        return (t.min_t == 4'd0) && (t.min_o == 4'd0) &&
               (t.sec_t == 4'd0) && (t.sec_o == 4'd1);
    endfunction

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_pkg::*;
(
    input  logic btn_mode,
    input  logic btn_run,
    input  logic tick,
    input  run_e state,
    input  logic at_zero,
    output cmd_e cmd
);

    // Priority: run button first, then mode button (halted only), then tick (running only).
    always_comb begin
        cmd = CMD_NONE;
        if (btn_run) begin
            cmd = at_zero ? CMD_RELOAD : CMD_TOGGLE;
        end else if (btn_mode && state == ST_HALT) begin
            cmd = CMD_MODE;
        end else if (tick && state == ST_RUN) begin
            cmd = CMD_TICK;
        end
    end

endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cmd_e  cmd,
    input  logic  at_zero,
    input  logic  last_step,
    output run_e  state,
    output mode_e mode
);

    run_e  state_q, state_d;
    mode_e mode_q,  mode_d;

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        unique case (cmd)
            CMD_TOGGLE: state_d = (state_q == ST_RUN) ? ST_HALT : ST_RUN;
            CMD_RELOAD: state_d = ST_HALT;
            CMD_MODE:   mode_d  = (mode_q == MODE_SHORT) ? MODE_LONG : MODE_SHORT;
            CMD_TICK:   if (last_step) state_d = ST_HALT;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HALT;
            mode_q  <= MODE_SHORT;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    assign state = state_q;
    assign mode  = mode_q;

    // R6: a running timer never sits at 0:00
    p_run_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RUN |-> !at_zero);

    // R3: the mode cannot change in the cycle after the timer was running
    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RUN |=> $stable(mode_q));

endmodule

// File: rtl/tmr_bcd_counter.sv
module tmr_bcd_counter
    import tmr_pkg::*;
#(
    parameter int unsigned RESET_SECS = 30
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  mmss_t load_val,
    input  logic  dec,
    output mmss_t count,
    output logic  at_zero,
    output logic  at_one
);

    localparam mmss_t RESET_VAL = secs_to_mmss(RESET_SECS);

    mmss_t count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= RESET_VAL;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && !mmss_is_zero(count_q)) begin
            count_q <= mmss_dec(count_q);
        end
    end

    assign count   = count_q;
    assign at_zero = mmss_is_zero(count_q);
    assign at_one  = mmss_is_one(count_q);

    // R5: digits stay valid BCD, seconds tens at most 5
    p_bcd_valid_r5: assert property (@(posedge clk) disable iff (rst)
        count_q.sec_o <= 4'd9 && count_q.sec_t <= 4'd5 &&
        count_q.min_o <= 4'd9 && count_q.min_t <= 4'd9);

    // R6: zero is held unless a load arrives
    p_zero_hold_r6: assert property (@(posedge clk) disable iff (rst)
        at_zero && !load |=> at_zero);

    // R5: a decrement from 1:00 lands on 0:59
    p_minute_borrow_r5: assert property (@(posedge clk) disable iff (rst)
        dec && !load && count_q == mmss_t'(16'h0100) |=> count_q == mmss_t'(16'h0059));

endmodule

// File: rtl/stop_timer_dual.sv
module stop_timer_dual
    import tmr_pkg::*;
#(
    parameter int unsigned SHORT_SECS = 30,
    parameter int unsigned LONG_SECS  = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1s,
    input  logic       btn_mode,
    input  logic       btn_run,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_ones,
    output logic       done
);

    localparam mmss_t PRESET_SHORT = secs_to_mmss(SHORT_SECS);
    localparam mmss_t PRESET_LONG  = secs_to_mmss(LONG_SECS);

    cmd_e  cmd;
    run_e  state;
    mode_e mode;
    mode_e load_mode;
    mmss_t count;
    mmss_t load_val;
    logic  at_zero;
    logic  at_one;
    logic  load;
    logic  dec;

    tmr_cmd_decode u_dec (
        .btn_mode (btn_mode),
        .btn_run  (btn_run),
        .tick     (tick_1s),
        .state    (state),
        .at_zero  (at_zero),
        .cmd      (cmd)
    );

    tmr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .at_zero   (at_zero),
        .last_step (at_one),
        .state     (state),
        .mode      (mode)
    );

    // A mode command loads the preset of the mode being switched to.
    always_comb begin
        load_mode = mode;
        if (cmd == CMD_MODE) begin
            load_mode = (mode == MODE_SHORT) ? MODE_LONG : MODE_SHORT;
        end
        load_val = (load_mode == MODE_LONG) ? PRESET_LONG : PRESET_SHORT;
    end

    assign load = (cmd == CMD_RELOAD) || (cmd == CMD_MODE);
    assign dec  = (cmd == CMD_TICK);

    tmr_bcd_counter #(
        .RESET_SECS (SHORT_SECS)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .count    (count),
        .at_zero  (at_zero),
        .at_one   (at_one)
    );

    assign min_tens = count.min_t;
    assign min_ones = count.min_o;
    assign sec_tens = count.sec_t;
    assign sec_ones = count.sec_o;
    assign done     = at_zero;

    // R4: a halted timer with no button activity keeps its count
    p_halt_stable_r4: assert property (@(posedge clk) disable iff (rst)
        state == ST_HALT && !btn_mode && !btn_run |=> $stable(count));

    // R8: a run press never decrements in the same cycle
    p_run_press_no_dec_r8: assert property (@(posedge clk) disable iff (rst)
        btn_run && !at_zero |=> $stable(count));

endmodule

// File: tb/tb_stop_timer_dual.sv
module tb_stop_timer_dual;

    localparam int SHORT_S = 30;
    localparam int LONG_S  = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1s = 1'b0;
    logic btn_mode = 1'b0;
    logic btn_run = 1'b0;
    logic [3:0] min_tens, min_ones, sec_tens, sec_ones;
    logic done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // model state
    bit m_long;
    bit m_run;
    int m_secs;

    always #2 clk = ~clk;

    stop_timer_dual dut (
        .clk      (clk),
        .rst      (rst),
        .tick_1s  (tick_1s),
        .btn_mode (btn_mode),
        .btn_run  (btn_run),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .sec_tens (sec_tens),
        .sec_ones (sec_ones),
        .done     (done)
    );

    function automatic int preset(input bit lng);
        return lng ? LONG_S : SHORT_S;
    endfunction

    function automatic logic [15:0] exp_digits(input int s);
        int mm, ss;
        mm = s / 60;
        ss = s % 60;
        return {4'((mm / 10) % 10), 4'(mm % 10), 4'(ss / 10), 4'(ss % 10)};
    endfunction

    task automatic model_step(input bit a, input bit b, input bit t);
        if (b) begin
            if (m_secs == 0) m_secs = preset(m_long);
            else m_run = !m_run;
        end else if (a && !m_run) begin
            m_long = !m_long;
            m_secs = preset(m_long);
        end else if (t && m_run) begin
            m_secs = m_secs - 1;
            if (m_secs == 0) m_run = 1'b0;
        end
    endtask

    task automatic chk(input string req);
        logic [15:0] got, exp;
        got = {min_tens, min_ones, sec_tens, sec_ones};
        exp = exp_digits(m_secs);
        n_checks++;
        if (got !== exp || done !== (m_secs == 0)) begin
            n_errors++;
            $display("FAIL %s: digits=%h done=%b expected digits=%h done=%b",
                     req, got, done, exp, (m_secs == 0));
        end
    endtask

    // Called at a falling edge; drives, lets one rising edge pass, returns at the next falling edge.
    task automatic cyc(input bit a, input bit b, input bit t);
        btn_mode = a;
        btn_run  = b;
        tick_1s  = t;
        @(posedge clk);
        model_step(a, b, t);
        @(negedge clk);
        btn_mode = 1'b0;
        btn_run  = 1'b0;
        tick_1s  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        m_long = 1'b0;
        m_run  = 1'b0;
        m_secs = SHORT_S;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        do_reset();
        chk("R1");                       // 0:30, done low
        cyc(1, 0, 0); chk("R2");         // long: 1:00
        cyc(1, 0, 0); chk("R2");         // back to 0:30
        cyc(0, 0, 1); chk("R4");         // stopped tick ignored
        cyc(0, 1, 0); chk("R4");         // start
        cyc(0, 0, 1); chk("R9");         // 0:29 one edge later
        cyc(1, 0, 0); chk("R3");         // mode press while running ignored
        cyc(1, 0, 1); chk("R3");         // mode + tick running: tick counts
        cyc(0, 1, 1); chk("R8");         // stop, no decrement
        cyc(0, 0, 1); chk("R4");         // stopped, held
        cyc(1, 0, 0); chk("R2");         // 1:00
        cyc(0, 1, 1); chk("R8");         // start, no decrement
        cyc(0, 0, 1); chk("R5");         // 0:59
        cyc(0, 0, 1); chk("R5");         // 0:58
        for (int i = 0; i < 7; i++) cyc(0, 0, 1);
        chk("R5");                        // 0:51
        cyc(0, 0, 1); chk("R5");          // 0:50
        cyc(0, 0, 1); chk("R5");          // 0:49
        for (int i = 0; i < 49; i++) cyc(0, 0, 1);
        chk("R6");                        // 0:00, done
        cyc(0, 0, 1); chk("R6");          // stays 0
        cyc(1, 0, 1); chk("R2");          // stopped at zero: mode press loads 0:30
        cyc(1, 0, 0); chk("R2");          // 1:00
        cyc(0, 1, 0);                     // start
        for (int i = 0; i < 60; i++) cyc(0, 0, 1);
        chk("R6");
        cyc(0, 1, 0); chk("R7");          // reload 1:00
        cyc(0, 0, 1); chk("R7");          // still stopped
        cyc(0, 1, 0); cyc(1, 1, 0); chk("R8"); // mode with run ignored, stops
        cyc(1, 0, 0); chk("R8");          // was stopped: mode press acts -> 0:30

        for (int i = 0; i < 6000; i++) begin
            bit a, b, t;
            a = ($urandom % 23) == 0;
            b = ($urandom % 29) == 0;
            t = ($urandom % 2) == 0;
            cyc(a, b, t);
            chk("R5");
            if (i == 3000) begin
                do_reset();
                chk("R1");
            end
        end
        finish_run();
    end

endmodule